// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block is the synchronous control core of a pipelined static RAM that supports bursts. At every rising clock edge it samples a chip select, a sleep input, a load/advance strobe, a write enable, active-low byte-lane selects and an active-low clock enable. From these it classifies the cycle as a deselect, a read, a dummy read, a write, a write abort, a stall or a sleep. A load cycle takes the external address. An advance cycle steps a 2-bit burst counter and repeats the kind of cycle that opened the burst: deselect, read or write.

Accesses go through a two-deep pipeline. Read data leaves the storage array two enabled edges after its address cycle. Write data is taken from the input lanes at the second enabled edge after its address cycle. Each byte lane is 9 bits wide (8 data bits and a parity bit). The lane output enables combine the pipeline state with an asynchronous output enable, so the lanes float whenever no read result is due and while write data is expected. A small behavioural array holds the data.

Top module: `bsram_cycle_ctrl`

## Requirements
- R1: A load cycle (ld_n=0) with sel_n=1 is a deselect: nothing is read or written, and dq_oe stays 0 for the cycle whose result it would have produced.
- R2: An advance cycle (ld_n=1) after a deselect or after reset is again a deselect, whatever wr_n and bsel_n are.
- R3: A load cycle with sel_n=0 and wr_n=1 starts a read at addr. After the second enabled edge, dq_o holds the addressed word, and every bit of dq_oe is 1 when oe_n=0.
- R4: A load cycle with sel_n=0, wr_n=0 and at least one bsel_n bit low starts a write. At the second enabled edge, lane i (dq_i bits [i*9 +: 9]) is stored only where bsel_n[i]=0.
- R5: A write cycle, whether load or advance, with every bsel_n bit high is a write abort and stores nothing. Inside a burst it cancels only that beat. An abort load still opens a write burst.
- R6: An advance cycle inside a read or write burst uses the next address. The low 2 bits count up and wrap modulo 4 (3 to 0), and the upper bits keep their value from the load cycle.
- R7: With cke_n=1 the edge is ignored: the burst address, the pipeline and dq_o all hold.
- R8: With sleep=1, dq_oe is 0 at once, the edge starts no access, and the open burst ends, so the next advance cycle is a deselect.
- R9: oe_n acts without a clock: oe_n=1 forces dq_oe to 0 immediately. A read issued with oe_n=1 (dummy read) still advances the burst address.
- R10: Between the first and second enabled edges after a write cycle, dq_oe is 0 even if a read result is due in that window.
- R11: While rst_n=0 and after reset, the block is deselected and dq_oe is 0 whatever oe_n is.
- R12: cyc_o reports the class of the coming edge: 0 deselect, 1 read, 2 dummy read (read with oe_n=1), 3 write, 4 write abort, 5 stall, 6 sleep. Sleep takes priority over stall, and stall over everything else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low combined chip select |
| sleep | input | 1 | Sleep request, active high |
| ld_n | input | 1 | Low: load external address; high: advance burst |
| wr_n | input | 1 | Active-low write enable |
| bsel_n | input | NB | Active-low byte-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cke_n | input | 1 | Active-low clock enable; high inserts a wait state |
| addr | input | AW | External word address |
| dq_i | input | NB*LW | Write data lanes (data plus parity per lane) |
| dq_o | output | NB*LW | Read data lanes |
| dq_oe | output | NB | Per-lane output drive enable |
| cyc_o | output | 3 | Class of the cycle being presented |

## Verification
The bench runs a burst that wraps from address 7 to address 4, with an abort beat at address 5 followed by a single-lane overwrite. If the counter did not wrap, or if the abort beat still stored its data, the later reads would return the wrong words. A stall is placed inside a read burst; a design that advanced the counter or the pipeline there would shift every later word by one. A read result is made due in the same window in which a write expects its data; if the masking were wrong, the lanes would drive into that write. Sleep in the middle of a burst, reset in the middle of a burst, and oe_n and sleep toggled with no clock edge are also covered, because a design that sampled either input on the clock, or kept the burst open, would drive the lanes when it must not.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    // class of the cycle presented at the coming edge (R12 encodings)
    typedef enum logic [2:0] {
        CY_DESEL  = 3'd0,
        CY_READ   = 3'd1,
        CY_DREAD  = 3'd2,
        CY_WRITE  = 3'd3,
        CY_WABORT = 3'd4,
        CY_STALL  = 3'd5,
        CY_SLEEP  = 3'd6
    } cyc_e;

    // kind of the open burst, inherited by advance cycles
    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_RD   = 2'd1,
        BK_WR   = 2'd2
    } bkind_e;

endpackage

// File: rtl/bsram_decode.sv
module bsram_decode
    import bsram_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          sleep,
    input  logic          cke_n,
    input  logic          sel_n,
    input  logic          ld_n,
    input  logic          wr_n,
    input  logic [NB-1:0] bsel_n,
    input  logic          oe_n,
    input  bkind_e        kind_q,
    output cyc_e          cyc,
    output bkind_e        kind_d,
    output logic          en,
    output logic          load,
    output logic          adv,
    output logic          do_rd,
    output logic          do_wr
);

    logic no_lane;
    assign no_lane = &bsel_n;

    always_comb begin
        cyc    = CY_STALL;
        kind_d = kind_q;
        en     = 1'b0;
        load   = 1'b0;
        adv    = 1'b0;
        do_rd  = 1'b0;
        do_wr  = 1'b0;
        if (sleep) begin
            cyc    = CY_SLEEP;
            en     = 1'b1;
            kind_d = BK_IDLE;
        end else if (cke_n) begin
            cyc = CY_STALL;
        end else if (!ld_n) begin
            en   = 1'b1;
            load = 1'b1;
            if (sel_n) begin
                cyc    = CY_DESEL;
                kind_d = BK_IDLE;
            end else if (wr_n) begin
                kind_d = BK_RD;
                do_rd  = 1'b1;
                cyc    = oe_n ? CY_DREAD : CY_READ;
            end else begin
                kind_d = BK_WR;
                do_wr  = !no_lane;
                cyc    = no_lane ? CY_WABORT : CY_WRITE;
            end
        end else begin
            en = 1'b1;
            unique case (kind_q)
                BK_RD: begin
                    adv   = 1'b1;
                    do_rd = 1'b1;
                    cyc   = oe_n ? CY_DREAD : CY_READ;
                end
                BK_WR: begin
                    adv   = 1'b1;
                    do_wr = !no_lane;
                    cyc   = no_lane ? CY_WABORT : CY_WRITE;
                end
                default: cyc = CY_DESEL;
            endcase
        end
    end

endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
    parameter int AW = 6,
    parameter int CW = 2
) (
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] ext_addr,
    input  logic [AW-CW-1:0] base_q,
    input  logic [CW-1:0] cnt_q,
    output logic [AW-CW-1:0] base_d,
    output logic [CW-1:0] cnt_d,
    output logic [AW-1:0] cyc_addr
);

    logic [CW-1:0] cnt_inc;
    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        base_d   = base_q;
        cnt_d    = cnt_q;
        cyc_addr = {base_q, cnt_inc};
        if (load) begin
            base_d   = ext_addr[AW-1:CW];
            cnt_d    = ext_addr[CW-1:0];
            cyc_addr = ext_addr;
        end else if (adv) begin
            cnt_d = cnt_inc;
        end
    end

endmodule

// File: rtl/bsram_store.sv
module bsram_store #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [NB-1:0]    be,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*LW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                mem[waddr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = mem[raddr];
    end

endmodule

// File: rtl/bsram_cycle_ctrl.sv
module bsram_cycle_ctrl
    import bsram_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int LW = 9,
    parameter int CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             sleep,
    input  logic             ld_n,
    input  logic             wr_n,
    input  logic [NB-1:0]    bsel_n,
    input  logic             oe_n,
    input  logic             cke_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*LW-1:0] dq_i,
    output logic [NB*LW-1:0] dq_o,
    output logic [NB-1:0]    dq_oe,
    output logic [2:0]       cyc_o
);

    localparam int DW = NB * LW;
    localparam int HW = AW - CW;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [NB-1:0] be;
        logic [AW-1:0] addr;
    } stage_t;

    typedef struct packed {
        bkind_e        kind;
        logic [HW-1:0] base;
        logic [CW-1:0] cnt;
        stage_t        p1;
        stage_t        p2;
        logic          rvld;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_q, st_d;

    cyc_e          cyc;
    bkind_e        kind_nx;
    logic          en, load, adv, do_rd, do_wr;
    logic [HW-1:0] base_nx;
    logic [CW-1:0] cnt_nx;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;

    bsram_decode #(.NB(NB)) dec_i (
        .sleep  (sleep),
        .cke_n  (cke_n),
        .sel_n  (sel_n),
        .ld_n   (ld_n),
        .wr_n   (wr_n),
        .bsel_n (bsel_n),
        .oe_n   (oe_n),
        .kind_q (st_q.kind),
        .cyc    (cyc),
        .kind_d (kind_nx),
        .en     (en),
        .load   (load),
        .adv    (adv),
        .do_rd  (do_rd),
        .do_wr  (do_wr)
    );

    bsram_burst #(.AW(AW), .CW(CW)) burst_i (
        .load     (load),
        .adv      (adv),
        .ext_addr (addr),
        .base_q   (st_q.base),
        .cnt_q    (st_q.cnt),
        .base_d   (base_nx),
        .cnt_d    (cnt_nx),
        .cyc_addr (cyc_addr)
    );

    assign mem_we = en && st_q.p2.wr;

    bsram_store #(.AW(AW), .NB(NB), .LW(LW)) store_i (
        .clk   (clk),
        .we    (mem_we),
        .be    (st_q.p2.be),
        .waddr (st_q.p2.addr),
        .wdata (dq_i),
        .raddr (st_q.p2.addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.kind    = kind_nx;
            st_d.base    = base_nx;
            st_d.cnt     = cnt_nx;
            st_d.p1.rd   = do_rd;
            st_d.p1.wr   = do_wr;
            st_d.p1.be   = do_wr ? ~bsel_n : '0;
            st_d.p1.addr = cyc_addr;
            st_d.p2      = st_q.p1;
            st_d.rvld    = st_q.p2.rd;
            if (st_q.p2.rd) begin
                st_d.rdata = mem_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_o  = st_q.rdata;
    assign dq_oe = {NB{st_q.rvld && !oe_n && !sleep && !st_q.p2.wr}};
    assign cyc_o = cyc;

endmodule

// File: rtl/bsram_cycle_ctrl_chk.sv
module bsram_cycle_ctrl_chk #(
    parameter int NB = 4,
    parameter int LW = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel_n,
    input logic             sleep,
    input logic             ld_n,
    input logic             wr_n,
    input logic [NB-1:0]    bsel_n,
    input logic             oe_n,
    input logic             cke_n,
    input logic [NB*LW-1:0] dq_o,
    input logic [NB-1:0]    dq_oe
);

    // R11
    always_comb begin
        if (!rst_n) begin
            reset_float_chk: assert (dq_oe == '0);
        end
    end

    // R8
    sleep_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (dq_oe == '0));

    // R9
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dq_oe == '0));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cke_n) |=> $stable(dq_o));

    // R10
    write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cke_n && !ld_n && !sel_n && !wr_n && (bsel_n != '1))
        ##1 (!sleep && !cke_n) |=> (dq_oe == '0));

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !cke_n && !ld_n && sel_n) ##1 (!sleep && !cke_n)
        ##1 (!sleep && !cke_n) |=> (dq_oe == '0));

endmodule

bind bsram_cycle_ctrl bsram_cycle_ctrl_chk #(.NB(NB), .LW(LW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .sleep  (sleep),
    .ld_n   (ld_n),
    .wr_n   (wr_n),
    .bsel_n (bsel_n),
    .oe_n   (oe_n),
    .cke_n  (cke_n),
    .dq_o   (dq_o),
    .dq_oe  (dq_oe)
);

// File: tb/bsram_cycle_ctrl_tb_top.sv
module bsram_cycle_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int LW = 9;
    localparam int DW = NB * LW;
    localparam int NROW = 31;

    localparam logic [DW-1:0] DZ  = 36'h0AA55AA55;
    localparam logic [DW-1:0] DA  = 36'h123456789;
    localparam logic [DW-1:0] DAP = 36'h1234567AB;
    localparam logic [DW-1:0] DB  = 36'h9ABCDEF01;
    localparam logic [DW-1:0] DC  = 36'h13579BDF0;
    localparam logic [DW-1:0] DE  = 36'h2468ACE02;
    localparam logic [DW-1:0] DF  = 36'h0F0F0F0F0;
    localparam logic [DW-1:0] GB  = 36'hFFFFFFFFF;
    localparam logic [DW-1:0] P0  = 36'h0000001AB;

    typedef struct packed {
        logic          sel_n;
        logic          slp;
        logic          ld_n;
        logic          wr_n;
        logic [3:0]    bs_n;
        logic          oe_n;
        logic          ck_n;
        logic [5:0]    ad;
        logic [DW-1:0] din;
        logic [2:0]    ecyc;
        logic          eoe;
        logic          cdq;
        logic [DW-1:0] edq;
    } row_t;

    // cyc codes: 0 desel, 1 read, 2 dummy read, 3 write, 4 abort, 5 stall, 6 sleep
    localparam row_t TBL [NROW] = '{
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b0,1'b0,36'h0}, // 0  R1
        '{1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,6'h00,36'h0,3'd0,1'b0,1'b0,36'h0}, // 1  R2
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b0,6'h05,36'h0,3'd3,1'b0,1'b0,36'h0}, // 2  R4
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b0,1'b0,36'h0}, // 3  R1
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b0,6'h06,DZ,  3'd3,1'b0,1'b0,36'h0}, // 4  R4
        '{1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,6'h00,36'h0,3'd3,1'b0,1'b0,36'h0}, // 5  R6
        '{1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,6'h00,DA,  3'd3,1'b0,1'b0,36'h0}, // 6  R6
        '{1'b0,1'b0,1'b1,1'b0,4'hF,1'b0,1'b0,6'h00,DB,  3'd4,1'b0,1'b0,36'h0}, // 7  R5
        '{1'b0,1'b0,1'b1,1'b0,4'hE,1'b0,1'b0,6'h00,DC,  3'd3,1'b0,1'b0,36'h0}, // 8  R4
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,GB,  3'd0,1'b0,1'b0,36'h0}, // 9  R1
        '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h06,P0,  3'd1,1'b0,1'b0,36'h0}, // 10 R3
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd1,1'b0,1'b0,36'h0}, // 11 R6
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd1,1'b1,1'b1,DAP},  // 12 R3
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,6'h00,36'h0,3'd2,1'b0,1'b1,DB},   // 13 R9
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd1,1'b1,1'b1,DC},   // 14 R6
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b1,6'h00,36'h0,3'd5,1'b1,1'b1,DC},   // 15 R7
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd1,1'b1,1'b1,DZ},   // 16 R5
        '{1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd6,1'b0,1'b1,DAP},  // 17 R8
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b1,1'b1,DB},   // 18 R8
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b0,1'b0,36'h0}, // 19 R8
        '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h07,36'h0,3'd1,1'b0,1'b0,36'h0}, // 20 R3
        '{1'b0,1'b0,1'b0,1'b0,4'h0,1'b0,1'b0,6'h20,36'h0,3'd3,1'b0,1'b0,36'h0}, // 21 R4
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b0,1'b1,DB},   // 22 R10
        '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h20,DE,  3'd1,1'b0,1'b0,36'h0}, // 23 R10
        '{1'b0,1'b0,1'b0,1'b0,4'hF,1'b0,1'b0,6'h30,36'h0,3'd4,1'b0,1'b0,36'h0}, // 24 R5
        '{1'b0,1'b0,1'b1,1'b0,4'h0,1'b0,1'b0,6'h00,36'h0,3'd3,1'b1,1'b1,DE},   // 25 R5
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,GB,  3'd0,1'b0,1'b0,36'h0}, // 26 R5
        '{1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h31,DF,  3'd1,1'b0,1'b0,36'h0}, // 27 R3
        '{1'b0,1'b0,1'b1,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd1,1'b0,1'b0,36'h0}, // 28 R6
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b1,1'b1,DF},   // 29 R4
        '{1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,1'b0,6'h00,36'h0,3'd0,1'b1,1'b0,36'h0}  // 30 R3
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_n, sleep, ld_n, wr_n, oe_n, cke_n;
    logic [NB-1:0] bsel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_i;
    logic [DW-1:0] dq_o;
    logic [NB-1:0] dq_oe;
    logic [2:0]    cyc_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bsram_cycle_ctrl #(.AW(AW), .NB(NB), .LW(LW), .CW(2)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_n  (sel_n),
        .sleep  (sleep),
        .ld_n   (ld_n),
        .wr_n   (wr_n),
        .bsel_n (bsel_n),
        .oe_n   (oe_n),
        .cke_n  (cke_n),
        .addr   (addr),
        .dq_i   (dq_i),
        .dq_o   (dq_o),
        .dq_oe  (dq_oe),
        .cyc_o  (cyc_o)
    );

    function automatic string row_req(int i);
        case (i)
            0, 3, 9:                return "R1";
            1:                      return "R2";
            10, 12, 20, 27, 30:     return "R3";
            2, 4, 8, 21, 29:        return "R4";
            7, 16, 24, 25, 26:      return "R5";
            5, 6, 11, 14, 28:       return "R6";
            15:                     return "R7";
            17, 18, 19:             return "R8";
            13:                     return "R9";
            default:                return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; sleep = 1'b0; ld_n = 1'b0; wr_n = 1'b1;
        bsel_n = '1; oe_n = 1'b0; cke_n = 1'b0; addr = '0; dq_i = '0;
        repeat (3) @(negedge clk);
        // R11: in reset with oe_n low the lanes float
        check(dq_oe == '0, "R11", "dq_oe in reset", 64'(dq_oe), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            sel_n = TBL[i].sel_n; sleep = TBL[i].slp; ld_n = TBL[i].ld_n;
            wr_n = TBL[i].wr_n; bsel_n = TBL[i].bs_n; oe_n = TBL[i].oe_n;
            cke_n = TBL[i].ck_n; addr = TBL[i].ad; dq_i = TBL[i].din;
            #1;
            // R12: cycle class before the edge
            check(cyc_o == TBL[i].ecyc, "R12", $sformatf("cyc_o row %0d", i),
                  64'(cyc_o), 64'(TBL[i].ecyc));
            @(negedge clk);
            check(dq_oe == {NB{TBL[i].eoe}}, row_req(i), $sformatf("dq_oe row %0d", i),
                  64'(dq_oe), 64'({NB{TBL[i].eoe}}));
            if (TBL[i].cdq) begin
                check(dq_o == TBL[i].edq, row_req(i), $sformatf("dq_o row %0d", i),
                      64'(dq_o), 64'(TBL[i].edq));
            end
        end

        // R9: oe_n gates the lanes with no clock edge (stall keeps state frozen)
        cke_n = 1'b1;
        #1;
        check(dq_oe == '1, "R9", "dq_oe with oe_n low", 64'(dq_oe), 64'hF);
        oe_n = 1'b1;
        #1;
        check(dq_oe == '0, "R9", "dq_oe after oe_n rise", 64'(dq_oe), 64'h0);
        oe_n = 1'b0;
        #1;
        check(dq_oe == '1, "R9", "dq_oe after oe_n fall", 64'(dq_oe), 64'hF);
        // R8: sleep floats the lanes at once
        sleep = 1'b1;
        #1;
        check(dq_oe == '0, "R8", "dq_oe under sleep", 64'(dq_oe), 64'h0);
        check(cyc_o == 3'd6, "R12", "sleep beats stall", 64'(cyc_o), 64'd6);
        sleep = 1'b0;
        @(negedge clk);
        // R7: stall held through the edge, result still present
        check(dq_oe == '1, "R7", "dq_oe after stall edge", 64'(dq_oe), 64'hF);

        // R11: reset mid-burst, then advance reads must stay deselected
        cke_n = 1'b0; sel_n = 1'b0; ld_n = 1'b0; wr_n = 1'b1; addr = 6'h04;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(dq_oe == '0, "R11", "dq_oe during reset", 64'(dq_oe), 64'h0);
        rst_n = 1'b1; ld_n = 1'b1;
        #1;
        check(cyc_o == 3'd0, "R11", "advance after reset", 64'(cyc_o), 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(dq_oe == '0, "R11", $sformatf("dq_oe after reset edge %0d", k),
                  64'(dq_oe), 64'h0);
        end

        finish_run();
    end

endmodule